// File: doc/BRIEF.md
# Dual-Port RAM with Same-Address Busy Arbitration

A synchronous true dual-port memory of 1024 bytes. Two ports, A and B, each have their own enable, write strobe, address, write data and registered read data. Either port can reach any word at any time. When both ports are enabled on the same address, an arbiter gives the word to one port and raises a busy flag toward the other. A write from the port that is told it is busy is held off until the flag drops.

In master mode the arbiter gives ownership to the port that arrived first. A port has arrived first when it was already enabled on that address in the previous cycle and the other port was not. When both arrive in the same cycle, port A wins. The winner keeps ownership until the two ports no longer collide. In slave mode the arbiter is bypassed: the block drives no busy flags, and busy inputs from an external master gate each port's writes instead. Several of these blocks can then be ganged side by side to form a wider word. A blocked write needs no queue. If the requester keeps its write strobe asserted, the write lands on the first clock edge at which the port is no longer busy.

Top module: `dpram_busy_arb`

## Requirements
- R1: While rst_n is low, both read data outputs are 0 and both busy outputs are 0.
- R2: When a port is enabled, its read data takes the addressed word at the clock edge, as it stood before any write made at that edge. When the port is not enabled, its read data holds its value.
- R3: A word written by one port is returned by a read on the other port that is sampled at the next edge or later. A read of the same word by the other port at the same edge returns the previous contents.
- R4: A busy output is raised only when both enables are high and the two 10-bit addresses are equal. Otherwise both busy outputs are 0.
- R5: In master mode, when a collision starts and only one port was enabled on that same address in the previous cycle, that port wins and the other port's busy output is 1 in the same cycle.
- R6: In master mode, when a collision starts and neither port was enabled on that address in the previous cycle, port A wins and b_busy_out is 1.
- R7: While a collision lasts over consecutive cycles, the winner does not change. The two busy outputs are never 1 together.
- R8: A write on a busy port is not performed. If enable and write strobe stay high, the write is performed at the first edge at which the port is not busy. If the strobe is dropped first, the write is abandoned.
- R9: In slave mode (slave_mode=1) both busy outputs are 0, and a port's write is suppressed whenever its busy input is 1. Reads still proceed.
- R10: In master mode the busy inputs have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slave_mode | input | 1 | 1 = busy taken from inputs, 0 = internal arbiter |
| a_en | input | 1 | Port A enable |
| a_we | input | 1 | Port A write strobe |
| a_addr | input | 10 | Port A address |
| a_wdata | input | 8 | Port A write data |
| a_busy_in | input | 1 | Port A external busy (slave mode) |
| a_busy_out | output | 1 | Port A lost arbitration (master mode) |
| a_rdata | output | 8 | Port A read data |
| b_en | input | 1 | Port B enable |
| b_we | input | 1 | Port B write strobe |
| b_addr | input | 10 | Port B address |
| b_wdata | input | 8 | Port B write data |
| b_busy_in | input | 1 | Port B external busy (slave mode) |
| b_busy_out | output | 1 | Port B lost arbitration (master mode) |
| b_rdata | output | 8 | Port B read data |

## Verification
The hardest situation to reach is a staggered collision that then resolves into a deferred write. It needs one port to sit on an address for a cycle, the second port to arrive there, and the winner to leave while the loser still holds its strobe. The stimulus table builds this as three consecutive rows: an early access from B, a colliding write from A, and B's release. The rows that follow read the word back from both ports, which shows that the old value was kept during the collision and that A's value arrived afterwards. A second sequence drops the loser's strobe before release, to show that the write is abandoned.

// File: rtl/dpram_busy_arb.sv
module dpram_busy_arb #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slave_mode,
  input  logic              a_en,
  input  logic              a_we,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [DATA_W-1:0] a_wdata,
  input  logic              a_busy_in,
  output logic              a_busy_out,
  output logic [DATA_W-1:0] a_rdata,
  input  logic              b_en,
  input  logic              b_we,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [DATA_W-1:0] b_wdata,
  input  logic              b_busy_in,
  output logic              b_busy_out,
  output logic [DATA_W-1:0] b_rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic              a_en_q, b_en_q;
  logic [ADDR_W-1:0] a_addr_q, b_addr_q;
  logic              lock_vld, lock_b;

  logic clash, a_held, b_held, b_wins, a_blk, b_blk, a_wr, b_wr;

  assign clash  = a_en && b_en && (a_addr == b_addr);
  assign a_held = a_en_q && (a_addr_q == a_addr);
  assign b_held = b_en_q && (b_addr_q == b_addr);
  assign b_wins = lock_vld ? lock_b : (b_held && !a_held);

  assign a_busy_out = !slave_mode && clash && b_wins;
  assign b_busy_out = !slave_mode && clash && !b_wins;

  assign a_blk = slave_mode ? a_busy_in : a_busy_out;
  assign b_blk = slave_mode ? b_busy_in : b_busy_out;
  assign a_wr  = a_en && a_we && !a_blk;
  assign b_wr  = b_en && b_we && !b_blk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_en_q   <= 1'b0;
      b_en_q   <= 1'b0;
      a_addr_q <= '0;
      b_addr_q <= '0;
      lock_vld <= 1'b0;
      lock_b   <= 1'b0;
    end else begin
      a_en_q   <= a_en;
      b_en_q   <= b_en;
      a_addr_q <= a_addr;
      b_addr_q <= b_addr;
      lock_vld <= clash;
      lock_b   <= b_wins;
    end
  end

  always_ff @(posedge clk) begin
    if (a_wr) mem[a_addr] <= a_wdata;
    if (b_wr) mem[b_addr] <= b_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_rdata <= '0;
      b_rdata <= '0;
    end else begin
      if (a_en) a_rdata <= mem[a_addr];
      if (b_en) b_rdata <= mem[b_addr];
    end
  end
endmodule

// File: rtl/dpram_busy_arb_chk.sv
module dpram_busy_arb_chk #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              slave_mode,
  input logic              a_en,
  input logic              b_en,
  input logic [ADDR_W-1:0] a_addr,
  input logic [ADDR_W-1:0] b_addr,
  input logic              a_busy_out,
  input logic              b_busy_out
);
  logic same;
  assign same = a_en && b_en && (a_addr == b_addr);

  assert_a_busy_needs_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
    a_busy_out |-> same);
  assert_b_busy_needs_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
    b_busy_out |-> same);
  assert_busy_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(a_busy_out && b_busy_out));
  assert_a_loser_stays_R7: assert property (@(posedge clk) disable iff (!rst_n)
    a_busy_out ##1 (same && !slave_mode) |-> a_busy_out);
  assert_b_loser_stays_R7: assert property (@(posedge clk) disable iff (!rst_n)
    b_busy_out ##1 (same && !slave_mode) |-> b_busy_out);
  assert_tie_goes_to_a_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (same && !slave_mode && !$past(a_en) && !$past(b_en)) |-> b_busy_out);
  assert_slave_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    slave_mode |-> (!a_busy_out && !b_busy_out));
endmodule

bind dpram_busy_arb dpram_busy_arb_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .slave_mode(slave_mode),
  .a_en(a_en), .b_en(b_en), .a_addr(a_addr), .b_addr(b_addr),
  .a_busy_out(a_busy_out), .b_busy_out(b_busy_out)
);

// File: tb/dpram_busy_arb_tb_top.sv
module dpram_busy_arb_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic slave_mode = 1'b0;
  logic a_en = 0, a_we = 0, a_busy_in = 0, b_en = 0, b_we = 0, b_busy_in = 0;
  logic [9:0] a_addr = '0, b_addr = '0;
  logic [7:0] a_wdata = '0, b_wdata = '0;
  logic a_busy_out, b_busy_out;
  logic [7:0] a_rdata, b_rdata;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dpram_busy_arb dut_i (
    .clk(clk), .rst_n(rst_n), .slave_mode(slave_mode),
    .a_en(a_en), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata),
    .a_busy_in(a_busy_in), .a_busy_out(a_busy_out), .a_rdata(a_rdata),
    .b_en(b_en), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata),
    .b_busy_in(b_busy_in), .b_busy_out(b_busy_out), .b_rdata(b_rdata)
  );

  typedef struct packed {
    logic [3:0] req;
    logic       sm;
    logic       ae, awe; logic [9:0] aad; logic [7:0] awd; logic abi;
    logic       be, bwe; logic [9:0] bad; logic [7:0] bwd; logic bbi;
    logic       xab, xbb;
    logic       cra; logic [7:0] xra;
    logic       crb; logic [7:0] xrb;
  } vec_t;

  function automatic vec_t mk(input int r, sm,
                              ae, awe, aad, awd, abi,
                              be, bwe, bad, bwd, bbi,
                              xab, xbb, cra, xra, crb, xrb);
    vec_t o;
    o.req = r[3:0];  o.sm = sm[0];
    o.ae = ae[0]; o.awe = awe[0]; o.aad = aad[9:0]; o.awd = awd[7:0]; o.abi = abi[0];
    o.be = be[0]; o.bwe = bwe[0]; o.bad = bad[9:0]; o.bwd = bwd[7:0]; o.bbi = bbi[0];
    o.xab = xab[0]; o.xbb = xbb[0];
    o.cra = cra[0]; o.xra = xra[7:0]; o.crb = crb[0]; o.xrb = xrb[7:0];
    return o;
  endfunction

  localparam int NV = 26;
  //                 req sm  A: en we addr  data bi   B: en we addr  data bi  busyA busyB  rdA        rdB
  localparam vec_t VEC [NV] = '{
    mk(10,0, 1,1,'h010,'h11,1, 1,1,'h040,'h5A,1, 0,0, 0,0,    0,0),     // R10 R4 busy_in ignored
    mk( 3,0, 1,0,'h040,0,0,    1,0,'h010,0,0,    0,0, 1,'h5A, 1,'h11), // R3 cross-port read
    mk( 2,0, 0,0,0,0,0,        0,0,0,0,0,        0,0, 1,'h5A, 1,'h11), // R2 hold when idle
    mk( 6,0, 1,1,'h040,'h77,0, 1,0,'h040,0,0,    0,1, 0,0,    1,'h5A), // R6 tie, R3 old word
    mk( 7,0, 1,0,'h040,0,0,    1,0,'h040,0,0,    0,1, 1,'h77, 1,'h77), // R7 R2
    mk( 4,0, 0,0,0,0,0,        0,0,0,0,0,        0,0, 0,0,    0,0),     // R4 idle
    mk( 4,0, 0,0,0,0,0,        1,1,'h050,'h60,0, 0,0, 0,0,    0,0),     // R4 one port
    mk( 5,0, 1,1,'h050,'hA1,0, 1,1,'h050,'h61,0, 1,0, 1,'h60, 0,0),     // R5 B earlier wins
    mk( 7,0, 1,1,'h050,'hA1,0, 1,0,'h050,0,0,    1,0, 1,'h61, 1,'h61), // R7 R8 A blocked
    mk( 8,0, 1,1,'h050,'hA1,0, 0,0,0,0,0,        0,0, 1,'h61, 0,0),     // R8 deferred write lands
    mk( 8,0, 0,0,0,0,0,        1,0,'h050,0,0,    0,0, 0,0,    1,'hA1), // R8 readback
    mk( 4,0, 1,1,'h060,'h01,0, 0,0,0,0,0,        0,0, 0,0,    0,0),     // R4
    mk( 5,0, 1,1,'h060,'h02,0, 1,1,'h060,'h03,0, 0,1, 1,'h01, 0,0),     // R5 A earlier wins
    mk( 8,0, 0,0,0,0,0,        1,1,'h060,'h03,0, 0,0, 0,0,    1,'h02), // R8 B write after release
    mk( 5,0, 1,0,'h060,0,0,    1,0,'h060,0,0,    1,0, 1,'h03, 1,'h03), // R5 B held wins
    mk( 4,0, 0,0,0,0,0,        0,0,0,0,0,        0,0, 0,0,    0,0),     // R4
    mk( 4,0, 1,1,'h070,'h10,0, 0,0,0,0,0,        0,0, 0,0,    0,0),     // R4
    mk( 8,0, 1,0,'h070,0,0,    1,1,'h070,'h20,0, 0,1, 1,'h10, 0,0),     // R8 B blocked
    mk( 8,0, 0,0,0,0,0,        1,0,'h070,0,0,    0,0, 0,0,    1,'h10), // R8 strobe dropped: abandoned
    mk( 4,0, 0,0,0,0,0,        0,0,0,0,0,        0,0, 0,0,    0,0),     // R4
    mk( 9,1, 1,1,'h080,'h44,0, 1,1,'h090,'h55,0, 0,0, 0,0,    0,0),     // R9 slave writes
    mk( 9,1, 1,1,'h080,'h99,1, 1,0,'h080,0,0,    0,0, 1,'h44, 1,'h44), // R9 A inhibited, no busy out
    mk( 9,1, 1,0,'h080,0,0,    1,1,'h090,'h66,1, 0,0, 1,'h44, 1,'h55), // R9 B inhibited
    mk( 9,1, 1,0,'h090,0,0,    0,0,0,0,0,        0,0, 1,'h55, 0,0),     // R9 readback
    mk( 9,1, 1,1,'h0A0,'h12,0, 1,1,'h0A0,'h34,1, 0,0, 0,0,    0,0),     // R9 only A writes
    mk( 9,1, 0,0,0,0,0,        1,0,'h0A0,0,1,    0,0, 0,0,    1,'h12)  // R9 read while busy_in
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 a_rdata", a_rdata, 8'h00);
    chk("R1 b_rdata", b_rdata, 8'h00);
    chk("R1 busy", {6'b0, a_busy_out, b_busy_out}, 8'h00);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      string tag;
      v = VEC[i];
      tag = $sformatf("R%0d vec %0d", v.req, i);
      slave_mode = v.sm;
      a_en = v.ae; a_we = v.awe; a_addr = v.aad; a_wdata = v.awd; a_busy_in = v.abi;
      b_en = v.be; b_we = v.bwe; b_addr = v.bad; b_wdata = v.bwd; b_busy_in = v.bbi;
      #5;
      chk({tag, " a_busy_out"}, {7'b0, a_busy_out}, {7'b0, v.xab});
      chk({tag, " b_busy_out"}, {7'b0, b_busy_out}, {7'b0, v.xbb});
      @(negedge clk);
      if (v.cra) chk({tag, " a_rdata"}, a_rdata, v.xra);
      if (v.crb) chk({tag, " b_rdata"}, b_rdata, v.xrb);
    end

    a_en = 0; b_en = 0; slave_mode = 0;
    @(negedge clk);
    rst_n = 1'b0;
    #5;
    chk("R1 a_rdata after reset", a_rdata, 8'h00);
    chk("R1 b_rdata after reset", b_rdata, 8'h00);
    @(negedge clk);
    summary();
  end
endmodule